// File: doc/BRIEF.md
# I2C Host Register Bridge

This block is a byte-addressed register window that sits between a simple synchronous host port and an I2C bit engine. The host programs a clock half-cycle value, a hold value, an address-byte count, a data-byte count and the contents of a shared byte buffer. It then writes a command byte that holds the 7-bit target address and a read flag. That write launches one transaction on the engine side. The bridge tracks the transaction with a three-state controller. `XS_IDLE` means ready. `XS_LAUNCH` lasts one cycle and raises the start pulse. `XS_WAIT` holds until the engine reports done. The transitions are: launch (idle to launch on an accepted command write), issue (launch to wait, unconditionally), complete (wait to idle on engine done), and abort (any state to idle on a soft reset).

Completion and acknowledge status are read from a status byte. Received bytes are read back from the buffer, starting at its first location. When the host has requested an SMBus block read and the slave acknowledges, the engine's reported length replaces the data-count register. The buffer depth is chosen by a size parameter that is also advertised in the capability byte. Host reads are strobed, and the read data appears one cycle after the strobe.

Top module: `hbr_top`

## Requirements
- R1: After reset, the bytes read back are: capability = {block-read support in bit 7, size code in bits 6:5, zeros}, which is 0x80 by default; control = 0x01; status = 0x01; half-cycle = 0x42; hold = 0x00.
- R2: A host write to offset 0x06 while idle and enabled raises `eng_start` for exactly one cycle, in the cycle after the write. During that cycle `eng_addr7` equals data[7:1] and `eng_rnw` equals data[0]. From that cycle on, status bit 0 (transfer-end) reads 0.
- R3: While a transaction is waiting, `eng_done` sets status bit 0 to 1 at the next edge. Status bit 4 takes the value of `eng_nack` at that same edge, so status reads 0x01 for an ACK and 0x11 for a NACK.
- R4: While status bit 0 is 0, host writes to the command (0x06), data-count (0x07), address-count (0x08) and buffer offsets are ignored. None of them raises `eng_start`.
- R5: The buffer occupies offsets 0x0A through 0x0A+depth-1, with a depth of 36 by default. Host writes to it are readable both by the host and on the engine read port at index offset-0x0A. Engine writes made during a transaction are readable by the host at the same offsets.
- R6: At completion with ACK, when address-count bit 7 (block read) is set and support is built in, data-count becomes `eng_blk_len`. With a NACK, or with bit 7 clear, data-count keeps its value.
- R7: Writing control bit 0 = 0 forces the controller to idle, with status 0x01 and `eng_abort` high. Command writes are then ignored until bit 0 is written back to 1.
- R8: If a soft-reset write and `eng_done` fall in the same cycle, the reset wins: status reads 0x01 and the NACK is not latched.
- R9: Offsets 0x02, 0x03 and those past the buffer read as 0x00, and writes to them change no register.
- R10: `eng_half_cyc`, `eng_hold`, `eng_data_cnt`, `eng_addr_cnt` (address-count bits 2:0) and `eng_blk` (address-count bit 7) follow the corresponding registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe; data appears next cycle |
| host_addr | input | 8 | Host byte offset |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered host read data |
| eng_start | output | 1 | One-cycle transaction launch |
| eng_abort | output | 1 | Engine held in soft reset |
| eng_addr7 | output | 7 | Target address |
| eng_rnw | output | 1 | 1 = read transaction |
| eng_addr_cnt | output | 3 | Leading address bytes |
| eng_data_cnt | output | 8 | Data byte count |
| eng_blk | output | 1 | Block-read request |
| eng_half_cyc | output | 8 | SCL half-cycle setting |
| eng_hold | output | 8 | Data hold setting |
| eng_done | input | 1 | Engine finished |
| eng_nack | input | 1 | Engine saw NACK; valid with done |
| eng_blk_len | input | 8 | Length returned by block read |
| eng_buf_we | input | 1 | Engine buffer write |
| eng_buf_idx | input | IDX_W | Engine buffer index |
| eng_buf_wdata | input | 8 | Engine buffer write data |
| eng_buf_rdata | output | 8 | Engine buffer read data |

## Verification
Two functions can meet in one cycle: the soft reset written through the control byte and the engine's done report with a NACK. The bench drives both at the same clock edge while the controller is waiting. It then expects status 0x01, with no latched NACK and no stale busy state. The second pair of functions meeting in one cycle is a command write and an in-flight transaction. These are provoked by writing the command, count and buffer offsets during the wait state, and the bench confirms that no extra start pulse appears and that every register keeps its value.

// File: rtl/hbr_pkg.sv
package hbr_pkg;

    typedef enum logic [1:0] {
        XS_IDLE   = 2'd0,
        XS_LAUNCH = 2'd1,
        XS_WAIT   = 2'd2
    } xfer_state_e;

    localparam logic [7:0] OFS_CAP  = 8'h00;
    localparam logic [7:0] OFS_CTRL = 8'h01;
    localparam logic [7:0] OFS_HALF = 8'h04;
    localparam logic [7:0] OFS_HOLD = 8'h05;
    localparam logic [7:0] OFS_CMD  = 8'h06;
    localparam logic [7:0] OFS_DCNT = 8'h07;
    localparam logic [7:0] OFS_ACNT = 8'h08;
    localparam logic [7:0] OFS_STAT = 8'h09;
    localparam logic [7:0] OFS_BUF  = 8'h0A;

    // buffer depth selected by the size code advertised in capability
    function automatic int buf_depth(input int code);
        case (code)
            1:       return 72;
            2:       return 132;
            default: return 36;
        endcase
    endfunction

endpackage

// File: rtl/hbr_xfer_fsm.sv
module hbr_xfer_fsm
    import hbr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic launch_req,
    input  logic soft_rst,
    input  logic eng_done,
    input  logic eng_nack,
    output logic eng_start,
    output logic busy,
    output logic wait_st,
    output logic done_acc,
    output logic nack_q
);

    xfer_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (soft_rst) begin
            state_d = XS_IDLE;
        end else begin
            unique case (state_q)
                XS_IDLE:   if (launch_req) state_d = XS_LAUNCH;
                XS_LAUNCH: state_d = XS_WAIT;
                XS_WAIT:   if (eng_done) state_d = XS_IDLE;
                default:   state_d = XS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= XS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        eng_start = (state_q == XS_LAUNCH);
        busy      = (state_q != XS_IDLE);
        wait_st   = (state_q == XS_WAIT);
        done_acc  = wait_st && eng_done && !soft_rst;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          nack_q <= 1'b0;
        else if (soft_rst)   nack_q <= 1'b0;
        else if (done_acc)   nack_q <= eng_nack;
        else if (launch_req) nack_q <= 1'b0;
    end

endmodule

// File: rtl/hbr_buf.sv
module hbr_buf #(
    parameter int DEPTH = 36,
    parameter int IW    = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          h_we,
    input  logic [IW-1:0] h_idx,
    input  logic [7:0]    h_wdata,
    output logic [7:0]    h_rdata,
    input  logic          e_we,
    input  logic [IW-1:0] e_idx,
    input  logic [7:0]    e_wdata,
    output logic [7:0]    e_rdata
);

    logic [7:0] mem [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_byte
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                mem[g] <= 8'h00;
            else if (h_we && (int'(h_idx) == g))
                mem[g] <= h_wdata;
            else if (e_we && (int'(e_idx) == g))
                mem[g] <= e_wdata;
        end
    end

    always_comb begin
        h_rdata = 8'h00;
        e_rdata = 8'h00;
        if (int'(h_idx) < DEPTH) h_rdata = mem[h_idx];
        if (int'(e_idx) < DEPTH) e_rdata = mem[e_idx];
    end

endmodule

// File: rtl/hbr_top.sv
module hbr_top
    import hbr_pkg::*;
#(
    parameter int         SIZE_CODE   = 0,
    parameter bit         BLK_SUPPORT = 1'b1,
    parameter logic [7:0] HALF_RST    = 8'h42,
    parameter int         IDX_W       = $clog2(buf_depth(SIZE_CODE))
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_wr,
    input  logic             host_rd,
    input  logic [7:0]       host_addr,
    input  logic [7:0]       host_wdata,
    output logic [7:0]       host_rdata,
    output logic             eng_start,
    output logic             eng_abort,
    output logic [6:0]       eng_addr7,
    output logic             eng_rnw,
    output logic [2:0]       eng_addr_cnt,
    output logic [7:0]       eng_data_cnt,
    output logic             eng_blk,
    output logic [7:0]       eng_half_cyc,
    output logic [7:0]       eng_hold,
    input  logic             eng_done,
    input  logic             eng_nack,
    input  logic [7:0]       eng_blk_len,
    input  logic             eng_buf_we,
    input  logic [IDX_W-1:0] eng_buf_idx,
    input  logic [7:0]       eng_buf_wdata,
    output logic [7:0]       eng_buf_rdata
);

    localparam int         DEPTH   = buf_depth(SIZE_CODE);
    localparam logic [1:0] SZ_BITS = 2'(SIZE_CODE);
    localparam logic [7:0] CAP_VAL = {BLK_SUPPORT, SZ_BITS, 5'b0};

    logic       run_q;
    logic [7:0] half_q, hold_q, cmd_q, dcnt_q, acnt_q;
    logic       xfer_busy, wait_st, done_acc, nack_q;
    logic       soft_rst, launch_req, is_buf, hbuf_we, ebuf_we;
    logic [7:0] buf_off, hbuf_rdata, rd_mux, stat_byte;
    logic       wr_ctrl, wr_idle_ok;

    always_comb begin
        wr_ctrl    = host_wr && (host_addr == OFS_CTRL);
        soft_rst   = (wr_ctrl && !host_wdata[0]) || !run_q;
        wr_idle_ok = host_wr && !xfer_busy;
        launch_req = wr_idle_ok && run_q && (host_addr == OFS_CMD);
        buf_off    = host_addr - OFS_BUF;
        is_buf     = (host_addr >= OFS_BUF) && (int'(buf_off) < DEPTH);
        hbuf_we    = wr_idle_ok && is_buf;
        ebuf_we    = eng_buf_we && wait_st;
        stat_byte  = {3'b000, nack_q, 3'b000, !xfer_busy};
    end

    hbr_xfer_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch_req (launch_req),
        .soft_rst   (soft_rst),
        .eng_done   (eng_done),
        .eng_nack   (eng_nack),
        .eng_start  (eng_start),
        .busy       (xfer_busy),
        .wait_st    (wait_st),
        .done_acc   (done_acc),
        .nack_q     (nack_q)
    );

    hbr_buf #(.DEPTH(DEPTH), .IW(IDX_W)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .h_we    (hbuf_we),
        .h_idx   (buf_off[IDX_W-1:0]),
        .h_wdata (host_wdata),
        .h_rdata (hbuf_rdata),
        .e_we    (ebuf_we),
        .e_idx   (eng_buf_idx),
        .e_wdata (eng_buf_wdata),
        .e_rdata (eng_buf_rdata)
    );

    // configuration registers, always writable
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q  <= 1'b1;
            half_q <= HALF_RST;
            hold_q <= 8'h00;
        end else if (host_wr) begin
            if (host_addr == OFS_CTRL) run_q  <= host_wdata[0];
            if (host_addr == OFS_HALF) half_q <= host_wdata;
            if (host_addr == OFS_HOLD) hold_q <= host_wdata;
        end
    end

    // transaction registers, writable only while idle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q  <= 8'h00;
            dcnt_q <= 8'h00;
            acnt_q <= 8'h00;
        end else begin
            if (launch_req)
                cmd_q <= host_wdata;
            if (done_acc && !eng_nack && BLK_SUPPORT && acnt_q[7])
                dcnt_q <= eng_blk_len;
            else if (wr_idle_ok && host_addr == OFS_DCNT)
                dcnt_q <= host_wdata;
            if (wr_idle_ok && host_addr == OFS_ACNT)
                acnt_q <= {host_wdata[7] & BLK_SUPPORT, 4'b0000, host_wdata[2:0]};
        end
    end

    always_comb begin
        unique case (host_addr)
            OFS_CAP:  rd_mux = CAP_VAL;
            OFS_CTRL: rd_mux = {7'b0, run_q};
            OFS_HALF: rd_mux = half_q;
            OFS_HOLD: rd_mux = hold_q;
            OFS_CMD:  rd_mux = cmd_q;
            OFS_DCNT: rd_mux = dcnt_q;
            OFS_ACNT: rd_mux = acnt_q;
            OFS_STAT: rd_mux = stat_byte;
            default:  rd_mux = is_buf ? hbuf_rdata : 8'h00;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       host_rdata <= 8'h00;
        else if (host_rd) host_rdata <= rd_mux;
    end

    always_comb begin
        eng_abort    = !run_q;
        eng_addr7    = cmd_q[7:1];
        eng_rnw      = cmd_q[0];
        eng_addr_cnt = acnt_q[2:0];
        eng_blk      = acnt_q[7];
        eng_data_cnt = dcnt_q;
        eng_half_cyc = half_q;
        eng_hold     = hold_q;
    end

endmodule

// File: rtl/hbr_checker.sv
module hbr_checker
    import hbr_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       host_wr,
    input logic [7:0] host_addr,
    input logic [7:0] host_wdata,
    input logic       eng_start,
    input logic       eng_done,
    input logic       eng_abort,
    input logic       xfer_busy
);

    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start);  // R2

    AST_START_FROM_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> $past(host_wr && host_addr == OFS_CMD));  // R2

    AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> !$past(xfer_busy));  // R4

    AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_busy && !eng_start && eng_done && !eng_abort &&
         !(host_wr && host_addr == OFS_CTRL && !host_wdata[0])) |=> !xfer_busy);  // R3

    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        eng_abort |-> !xfer_busy);  // R7

    AST_RESET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == OFS_CTRL && !host_wdata[0]) |=> !xfer_busy);  // R8

endmodule

bind hbr_top hbr_checker u_hbr_checker (.*);

// File: tb/hbr_top_bench.sv
`timescale 1ns/1ps
module hbr_top_bench;

    localparam int IW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0]    host_addr = 8'h00, host_wdata = 8'h00;
    logic [7:0]    host_rdata;
    logic          eng_start, eng_abort, eng_rnw, eng_blk;
    logic [6:0]    eng_addr7;
    logic [2:0]    eng_addr_cnt;
    logic [7:0]    eng_data_cnt, eng_half_cyc, eng_hold;
    logic          eng_done = 1'b0, eng_nack = 1'b0;
    logic [7:0]    eng_blk_len = 8'h00;
    logic          eng_buf_we = 1'b0;
    logic [IW-1:0] eng_buf_idx = '0;
    logic [7:0]    eng_buf_wdata = 8'h00;
    logic [7:0]    eng_buf_rdata;

    always #2.5 clk = ~clk;

    hbr_top u_hbr_top (.*);

    typedef struct packed { logic [6:0] a; logic rnw; } start_t;
    start_t exp_q[$];
    int n_vec = 0, n_bad = 0;
    bit finished = 0;

    task automatic check8(string tag, logic [7:0] act, logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd_chk(string tag, logic [7:0] a, logic [7:0] exp);
        @(negedge clk);
        host_rd = 1'b1; host_addr = a;
        @(negedge clk);
        host_rd = 1'b0;
        check8(tag, host_rdata, exp);
    endtask

    task automatic launch(logic [6:0] a, logic rnw);
        start_t s;
        s.a = a; s.rnw = rnw;
        exp_q.push_back(s);
        wr(8'h06, {a, rnw});
    endtask

    task automatic finish_xfer(logic nack, logic [7:0] blen);
        @(negedge clk);
        eng_done = 1'b1; eng_nack = nack; eng_blk_len = blen;
        @(negedge clk);
        eng_done = 1'b0; eng_nack = 1'b0;
    endtask

    // scoreboard monitor for launch pulses
    always @(negedge clk) begin
        if (rst_n && eng_start) begin
            start_t s;
            n_vec++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R2 unexpected start actual=%02h%0d expected=none", eng_addr7, eng_rnw);
            end else begin
                s = exp_q.pop_front();
                if (eng_addr7 !== s.a || eng_rnw !== s.rnw) begin
                    n_bad++;
                    $display("FAIL R2 start actual=%02h/%0d expected=%02h/%0d",
                             eng_addr7, eng_rnw, s.a, s.rnw);
                end
            end
        end
    end

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd_chk("R1 cap", 8'h00, 8'h80);
        rd_chk("R1 ctrl", 8'h01, 8'h01);
        rd_chk("R1 status", 8'h09, 8'h01);
        rd_chk("R1 half", 8'h04, 8'h42);
        rd_chk("R1 hold", 8'h05, 8'h00);
        // R10 engine-facing settings
        wr(8'h04, 8'h0E); wr(8'h05, 8'h03); wr(8'h07, 8'h05); wr(8'h08, 8'h82);
        check8("R10 half", eng_half_cyc, 8'h0E);
        check8("R10 hold", eng_hold, 8'h03);
        check8("R10 dcnt", eng_data_cnt, 8'h05);
        check8("R10 acnt", {5'b0, eng_addr_cnt}, 8'h02);
        check8("R10 blk", {7'b0, eng_blk}, 8'h01);
        // R5 buffer
        for (int i = 0; i < 4; i++) wr(8'h0A + 8'(i), 8'hA0 + 8'(i));
        wr(8'h2D, 8'h5C);
        rd_chk("R5 buf0", 8'h0A, 8'hA0);
        rd_chk("R5 buf3", 8'h0D, 8'hA3);
        rd_chk("R5 buf35", 8'h2D, 8'h5C);
        @(negedge clk); eng_buf_idx = 6'd1; #1;
        check8("R5 eng rd1", eng_buf_rdata, 8'hA1);
        eng_buf_idx = 6'd35; #1;
        check8("R5 eng rd35", eng_buf_rdata, 8'h5C);
        // R9 unmapped
        rd_chk("R9 ofs2", 8'h02, 8'h00);
        wr(8'h03, 8'hFF);
        rd_chk("R9 ofs3", 8'h03, 8'h00);
        wr(8'h2E, 8'h77);
        rd_chk("R9 past buf", 8'h2E, 8'h00);
        rd_chk("R9 last byte kept", 8'h2D, 8'h5C);
        // R2 launch, R4 writes while busy, R6 block length
        launch(7'h50, 1'b1);
        rd_chk("R2 status busy", 8'h09, 8'h00);
        wr(8'h06, 8'h44); wr(8'h07, 8'h09); wr(8'h08, 8'h01); wr(8'h0A, 8'hEE);
        rd_chk("R4 dcnt kept", 8'h07, 8'h05);
        rd_chk("R4 acnt kept", 8'h08, 8'h82);
        rd_chk("R4 buf kept", 8'h0A, 8'hA0);
        check8("R4 cmd kept", {eng_addr7, eng_rnw}, 8'hA1);
        @(negedge clk);
        eng_buf_we = 1'b1; eng_buf_idx = 6'd0; eng_buf_wdata = 8'h11;
        @(negedge clk);
        eng_buf_idx = 6'd1; eng_buf_wdata = 8'h22;
        @(negedge clk);
        eng_buf_we = 1'b0;
        finish_xfer(1'b0, 8'h03);
        rd_chk("R3 status ack", 8'h09, 8'h01);
        rd_chk("R6 dcnt block len", 8'h07, 8'h03);
        rd_chk("R5 eng write buf0", 8'h0A, 8'h11);
        rd_chk("R5 eng write buf1", 8'h0B, 8'h22);
        // R3 nack, R6 unchanged without ack / without flag
        wr(8'h08, 8'h82);
        launch(7'h22, 1'b0);
        finish_xfer(1'b1, 8'h07);
        rd_chk("R3 status nack", 8'h09, 8'h11);
        rd_chk("R6 dcnt kept on nack", 8'h07, 8'h03);
        wr(8'h08, 8'h01);
        launch(7'h22, 1'b0);
        finish_xfer(1'b0, 8'h09);
        rd_chk("R3 status ack2", 8'h09, 8'h01);
        rd_chk("R6 dcnt kept no flag", 8'h07, 8'h03);
        // R7 soft reset
        launch(7'h10, 1'b0);
        wr(8'h01, 8'h00);
        rd_chk("R7 status idle", 8'h09, 8'h01);
        check8("R7 abort", {7'b0, eng_abort}, 8'h01);
        wr(8'h06, 8'h30);
        rd_chk("R7 cmd ignored", 8'h06, 8'h20);
        wr(8'h01, 8'h01);
        check8("R7 abort off", {7'b0, eng_abort}, 8'h00);
        // R8 reset and done in the same cycle
        launch(7'h11, 1'b1);
        @(negedge clk);
        host_wr = 1'b1; host_addr = 8'h01; host_wdata = 8'h00;
        eng_done = 1'b1; eng_nack = 1'b1;
        @(negedge clk);
        host_wr = 1'b0; eng_done = 1'b0; eng_nack = 1'b0;
        rd_chk("R8 reset wins", 8'h09, 8'h01);
        wr(8'h01, 8'h01);
        repeat (4) @(negedge clk);
        n_vec++;
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL R2 pending starts actual=%0d expected=0", exp_q.size());
        end
        report();
    end

endmodule